// File: doc/BRIEF.md
# Noise-Shaping Error-Feedback Requantizer

This block shortens a wide, oversampled two's complement sample stream to a few-bit word so that a downstream filter can work with cheap arithmetic. Each accepted sample is corrected by a prediction of the recent requantization error and then clamped to the input range. Only its top bits are kept. The part that is dropped is stored as the new error.

The correction is a short FIR filter over the stored errors. Its taps are fixed signed parameters with 8 fractional bits. Because the filter sits behind a one-sample delay inside a negative feedback loop, the noise transfer function becomes 1 − z⁻¹·P(z). The default taps (2.0, −1.0, 0, 0) give a second-order zero at DC, which moves the requantization noise out of the low-frequency band of interest. Cycles in which the input strobe is low leave the loop untouched, so the stream may arrive with gaps.

Top module: `ef_requantizer`

## Requirements
- R1: A synchronous reset (active-high `rst`) clears the output word to 0, drives `out_valid` low and clears every stored error to zero.
- R2: For every accepted sample the output word is floor(v / 2^(IN_W−OUT_W)), which is the upper OUT_W bits of v. Here v is the corrected and clamped sample, and the word is read as signed two's complement.
- R3: The correction is the sum over taps i of floor(c_i · q[k−1−i] / 256). In this sum, q[j] = y[j]·2^(IN_W−OUT_W) − v[j] is the error of accepted sample j, tap 0 weights the most recent error, and the default taps are c = (512, −256, 0, 0), which is 2.0 and −1.0 in 8-fractional-bit form. The correction is subtracted from the input.
- R4: The first sample accepted after reset is output as its own upper OUT_W bits, because the correction is then zero.
- R5: `out_valid` is high exactly one clock after a clock in which `in_valid` was high, and the new word appears on that same cycle.
- R6: A clock with `in_valid` low changes neither the output word nor the stored errors. The next accepted sample therefore produces the same word as if the idle clock had not occurred.
- R7: The corrected sample saturates to [−32768, 32767] before quantization, so full-scale inputs give codes 7 or −8 and never wrap.
- R8: Over 1024 consecutive accepted samples of a constant input within ±24000, the mean of y·2^(IN_W−OUT_W) lies within 64 LSB of that input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | IN_W | Signed wide input sample |
| out_valid | output | 1 | Output word strobe |
| out_code | output | OUT_W | Signed short output word |

## Verification
A sample driven with `in_valid` high on one clock yields its word, and `out_valid`, right after that edge. The bench drives each stimulus just after a falling edge and compares at the next falling edge, which is half a period after the single register stage. On idle clocks it checks that the previous word and a low strobe are still present. The effect of the error history appears only on the accepted sample that follows. A bit-exact arithmetic model in the bench tracks that history, advancing only on accepted samples, so a history that moved on an idle clock shows up as a wrong word one accepted sample later.

// File: rtl/ef_rq_pkg.sv
package ef_rq_pkg;
   // Default prediction taps, 12-bit signed, 8 fractional bits, tap 0 in LSBs:
   // P(z) = 2 - z^-1 gives a noise transfer function of (1 - z^-1)^2.
   localparam int unsigned DEF_COEF_W = 12;
   localparam int unsigned DEF_NTAPS  = 4;
   localparam logic [DEF_NTAPS*DEF_COEF_W-1:0] DEF_TAPS =
      {12'h000, 12'h000, 12'hF00, 12'h200};

   // Width of a sum of n terms of width w.
   function automatic int unsigned sum_width(input int unsigned w, input int unsigned n);
      return w + $clog2(n) + 1;
   endfunction
endpackage

// File: rtl/ef_rq_history.sv
module ef_rq_history #(
   parameter int unsigned NTAPS = 4,
   parameter int unsigned ERR_W = 13
) (
   input  logic                              clk,
   input  logic                              rst,
   input  logic                              shift_en,
   input  logic signed [ERR_W-1:0]           err_in,
   output logic        [NTAPS-1:0][ERR_W-1:0] hist_out
);
   logic [NTAPS-1:0][ERR_W-1:0] stage_q;

   generate
      for (genvar s = 0; s < NTAPS; s++) begin : g_stage
         if (s == 0) begin : g_head
            always_ff @(posedge clk) begin
               if (rst)           stage_q[s] <= '0;
               else if (shift_en) stage_q[s] <= err_in;
            end
         end else begin : g_tail
            always_ff @(posedge clk) begin
               if (rst)           stage_q[s] <= '0;
               else if (shift_en) stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign hist_out = stage_q;

   // R3: the newest stored error is the one produced by the accepted sample
   a_r3_newest_error: assert property (@(posedge clk) disable iff (rst)
      shift_en |=> hist_out[0] == $past(err_in));

   // R6: idle clocks leave the error history untouched
   a_r6_history_hold: assert property (@(posedge clk) disable iff (rst)
      !shift_en |=> $stable(hist_out));
endmodule

// File: rtl/ef_rq_predictor.sv
module ef_rq_predictor #(
   parameter int unsigned NTAPS  = 4,
   parameter int unsigned ERR_W  = 13,
   parameter int unsigned COEF_W = 12,
   parameter int unsigned FRAC   = 8,
   parameter logic [NTAPS*COEF_W-1:0] TAPS = '0,
   parameter int unsigned ACC_W  = 20
) (
   input  logic                               clk,
   input  logic                               rst,
   input  logic        [NTAPS-1:0][ERR_W-1:0] hist_in,
   output logic signed [ACC_W-1:0]            corr_out
);
   localparam int unsigned PROD_W = ERR_W + COEF_W;
   localparam int unsigned TERM_W = PROD_W - FRAC;

   logic signed [ACC_W-1:0] term_ext [NTAPS];

   generate
      for (genvar t = 0; t < NTAPS; t++) begin : g_tap
         localparam logic signed [COEF_W-1:0] C = TAPS[t*COEF_W +: COEF_W];
         if (C == '0) begin : g_zero
            // A zero tap costs no multiplier.
            assign term_ext[t] = '0;
         end else begin : g_mul
            logic signed [PROD_W-1:0] prod;
            logic        [TERM_W-1:0] term;
            assign prod = C * $signed(hist_in[t]);
            // Dropping the fractional bits of a two's complement value is a floor.
            assign term = prod[PROD_W-1:FRAC];
            assign term_ext[t] = {{(ACC_W-TERM_W){term[TERM_W-1]}}, term};
         end
      end
   endgenerate

   always_comb begin
      corr_out = '0;
      for (int t = 0; t < NTAPS; t++) corr_out = corr_out + term_ext[t];
   end

   // R3: with an empty history no correction is applied
   a_r3_zero_history: assert property (@(posedge clk) disable iff (rst)
      (hist_in == '0) |-> (corr_out == '0));
endmodule

// File: rtl/ef_rq_quantizer.sv
module ef_rq_quantizer #(
   parameter int unsigned IN_W  = 16,
   parameter int unsigned OUT_W = 4,
   parameter int unsigned ACC_W = 20
) (
   input  logic signed [IN_W-1:0]        x_in,
   input  logic signed [ACC_W-1:0]       corr_in,
   output logic        [OUT_W-1:0]       code_out,
   output logic signed [IN_W-OUT_W:0]    err_out,
   output logic                          clip_out
);
   localparam int unsigned SHIFT = IN_W - OUT_W;
   localparam int unsigned SUM_W = ACC_W + 1;

   logic signed [SUM_W-1:0] diff;
   logic        [IN_W-1:0]  clamped;
   logic                    upper_same;

   assign diff = {{(SUM_W-IN_W){x_in[IN_W-1]}}, x_in} - {corr_in[ACC_W-1], corr_in};

   // The result fits IN_W bits when all bits from the top down to IN_W-1 agree.
   assign upper_same = (diff[SUM_W-1:IN_W-1] == '0) || (diff[SUM_W-1:IN_W-1] == '1);
   assign clip_out   = !upper_same;

   always_comb begin
      if (upper_same)            clamped = diff[IN_W-1:0];
      else if (diff[SUM_W-1])    clamped = {1'b1, {(IN_W-1){1'b0}}};
      else                       clamped = {1'b0, {(IN_W-1){1'b1}}};
   end

   assign code_out = clamped[IN_W-1:SHIFT];
   // Output scaled back minus quantizer input: minus the discarded low bits.
   assign err_out  = -$signed({1'b0, clamped[SHIFT-1:0]});
endmodule

// File: rtl/ef_requantizer.sv
module ef_requantizer #(
   parameter int unsigned IN_W   = 16,
   parameter int unsigned OUT_W  = 4,
   parameter int unsigned NTAPS  = ef_rq_pkg::DEF_NTAPS,
   parameter int unsigned COEF_W = ef_rq_pkg::DEF_COEF_W,
   parameter int unsigned FRAC   = 8,
   parameter logic [NTAPS*COEF_W-1:0] TAPS = ef_rq_pkg::DEF_TAPS
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [IN_W-1:0]  in_sample,
   output logic             out_valid,
   output logic [OUT_W-1:0] out_code
);
   localparam int unsigned SHIFT  = IN_W - OUT_W;
   localparam int unsigned ERR_W  = SHIFT + 1;
   localparam int unsigned TERM_W = ERR_W + COEF_W - FRAC;
   localparam int unsigned ACC_W  = ef_rq_pkg::sum_width(TERM_W, NTAPS);

   generate
      if (OUT_W < 2 || OUT_W >= IN_W) begin : g_bad_width
         $error("ef_requantizer: OUT_W must lie in [2, IN_W-1]");
      end
      if (NTAPS < 1) begin : g_bad_taps
         $error("ef_requantizer: NTAPS must be at least 1");
      end
      if (FRAC >= ERR_W + COEF_W) begin : g_bad_frac
         $error("ef_requantizer: FRAC too large for the product width");
      end
      if (ACC_W < IN_W) begin : g_bad_acc
         $error("ef_requantizer: accumulator narrower than the input");
      end
   endgenerate

   logic [NTAPS-1:0][ERR_W-1:0] hist;
   logic signed [ACC_W-1:0]     corr;
   logic        [OUT_W-1:0]     code_d;
   logic signed [ERR_W-1:0]     err_d;
   logic                        clip;
   logic                        valid_q;
   logic        [OUT_W-1:0]     code_q;

   ef_rq_history #(.NTAPS(NTAPS), .ERR_W(ERR_W)) hist_i (
      .clk(clk), .rst(rst), .shift_en(in_valid), .err_in(err_d), .hist_out(hist));

   ef_rq_predictor #(.NTAPS(NTAPS), .ERR_W(ERR_W), .COEF_W(COEF_W), .FRAC(FRAC),
                     .TAPS(TAPS), .ACC_W(ACC_W)) pred_i (
      .clk(clk), .rst(rst), .hist_in(hist), .corr_out(corr));

   ef_rq_quantizer #(.IN_W(IN_W), .OUT_W(OUT_W), .ACC_W(ACC_W)) quant_i (
      .x_in($signed(in_sample)), .corr_in(corr), .code_out(code_d),
      .err_out(err_d), .clip_out(clip));

   always_ff @(posedge clk) begin
      if (rst) begin
         valid_q <= 1'b0;
         code_q  <= '0;
      end else begin
         valid_q <= in_valid;
         if (in_valid) code_q <= code_d;
      end
   end

   assign out_valid = valid_q;
   assign out_code  = code_q;

   // R5: a strobe in yields a strobe out one clock later, and only then
   a_r5_valid_follows: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
   a_r5_idle_follows: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);

   // R6: the output word holds across idle clocks
   a_r6_code_hold: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(out_code));

   // R4: with no correction pending the word is the sample's upper bits
   a_r4_plain_truncate: assert property (@(posedge clk) disable iff (rst)
      (in_valid && corr == '0) |=> out_code == $past(in_sample[IN_W-1:SHIFT]));

   // R7: a clipped sample lands on an extreme code of matching sign
   a_r7_clip_extreme: assert property (@(posedge clk) disable iff (rst)
      (in_valid && clip) |=> (out_code == {1'b0, {(OUT_W-1){1'b1}}}) ||
                             (out_code == {1'b1, {(OUT_W-1){1'b0}}}));
endmodule

// File: tb/ef_requantizer_tb_top.sv
module ef_requantizer_tb_top;
   localparam int IN_W  = 16;
   localparam int OUT_W = 4;
   localparam int SHIFT = IN_W - OUT_W;
   localparam int NT    = 4;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             in_valid = 1'b0;
   logic [IN_W-1:0]  in_sample = '0;
   logic             out_valid;
   logic [OUT_W-1:0] out_code;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   int taps [NT] = '{512, -256, 0, 0};
   int mq   [NT];
   int last_y;

   ef_requantizer dut_i (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
      .out_valid(out_valid), .out_code(out_code));

   always #10 clk = ~clk;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic model_clear();
      for (int i = 0; i < NT; i++) mq[i] = 0;
      last_y = 0;
   endtask

   // Arithmetic reference from R2, R3, R7.
   task automatic model_step(input int x, output int y);
      int corr, v;
      corr = 0;
      for (int i = 0; i < NT; i++) corr += (taps[i] * mq[i]) >>> 8;
      v = x - corr;
      if (v > 32767)  v = 32767;
      if (v < -32768) v = -32768;
      y = v >>> SHIFT;
      for (int i = NT - 1; i > 0; i--) mq[i] = mq[i-1];
      mq[0] = y * (1 << SHIFT) - v;
   endtask

   // Called at a falling edge; drives, waits one clock, compares.
   task automatic step(input bit v, input int x, input string req, output int y);
      int ey;
      in_valid  = v;
      in_sample = x[IN_W-1:0];
      if (v) model_step(x, ey);
      else   ey = last_y;
      @(negedge clk);
      check(out_valid == v, "R5 valid", int'(out_valid), int'(v));
      y = int'($signed(out_code));
      check(y == ey, req, y, ey);
      last_y = ey;
   endtask

   task automatic do_reset();
      in_valid = 1'b0;
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      model_clear();
      check(out_valid == 1'b0, "R1 valid after reset", int'(out_valid), 0);
      check(out_code == '0, "R1 code after reset", int'($signed(out_code)), 0);
   endtask

   initial begin
      int y, k, sum;
      model_clear();
      @(negedge clk);
      do_reset();

      // R4: first accepted sample is its plain truncation
      step(1'b1, -20000, "R4 first after reset", y);
      check(y == (-20000 >>> SHIFT), "R4 truncation", y, -20000 >>> SHIFT);

      // R2 R3 R6: sweep of the input range with idle gaps
      k = 0;
      for (int x = -32768; x <= 32767; x += 97) begin
         step(1'b1, x, "R2 R3 sweep", y);
         if (k % 5 == 4) step(1'b0, 12345, "R6 idle hold", y);
         k++;
      end

      // R3: alternating pattern stresses the feedback sign
      for (int i = 0; i < 64; i++) step(1'b1, (i % 2) ? 9000 : -9000, "R3 alternating", y);

      // R7: full-scale drive in both directions
      for (int i = 0; i < 40; i++) begin
         step(1'b1, 32767, "R7 positive full scale", y);
         check(y == 7 || y == 6, "R7 positive no wrap", y, 7);
      end
      for (int i = 0; i < 40; i++) begin
         step(1'b1, -32768, "R7 negative full scale", y);
         check(y == -8 || y == -7, "R7 negative no wrap", y, -8);
      end

      // R1 R4: reset in mid-stream drops the pending history
      do_reset();
      step(1'b1, 31000, "R4 first after mid reset", y);
      check(y == (31000 >>> SHIFT), "R1 history cleared", y, 31000 >>> SHIFT);

      // R8: DC tracking over long constant runs
      foreach (taps[i]) begin end
      for (int d = 0; d < 3; d++) begin
         int dc;
         dc = (d == 0) ? 1000 : (d == 1) ? -7000 : 12000;
         sum = 0;
         for (int i = 0; i < 1024; i++) begin
            step(1'b1, dc, "R8 DC run", y);
            sum += y * (1 << SHIFT) - dc;
         end
         check(sum <= 64 * 1024 && sum >= -64 * 1024, "R8 mean error x1024", sum, 0);
      end

      // R6: several idle clocks then a sample that depends on history
      for (int i = 0; i < 5; i++) step(1'b0, -1, "R6 idle hold", y);
      step(1'b1, 5555, "R6 history after idle", y);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule